// File: doc/BRIEF.md
# Predicated SIMD Byte-Lane Write Mask

This block sits between a 64-bit partitioned SIMD ALU and a register file that accepts one write enable per byte. For each destination write it takes the ALU result and an 8-bit predicate. It also takes an element-width code, an invert flag, a zeroing flag and a flag that says whether the operation is predicated at all. From these it produces the write data word and the eight byte write enables for a single register write.

Each predicate bit is spread across every byte of the element it governs. Predicate bit i controls element i, and element 0 sits in the least significant bytes. A 64-bit operation reads one predicate bit, 32-bit reads two, 16-bit reads four and 8-bit reads all eight. In non-zeroing mode the spread mask becomes the byte write enables directly. The old destination value is therefore never read: the bytes that are masked out are simply not written. In zeroing mode every byte is written, and the masked-out elements carry zero in the data.

The inputs are sampled on a valid strobe. The data word, the enables and a valid flag appear one clock later.

Top module: `lane_wmask_unit`

## Requirements
- R1: `out_valid` equals `in_valid` from the previous clock. After reset, `out_valid`, `out_be` and `out_data` are all zero.
- R2: When `in_valid` is low, `out_be` is 0 on the following cycle, whatever the predicate, the mode or the width.
- R3: The width code in `in_ew` is 2'b00 for 64-bit, 2'b01 for 32-bit, 2'b10 for 16-bit and 2'b11 for 8-bit. For width W, element i covers bytes i*(W/8) through (i+1)*(W/8)-1, and predicate bit i (bit 0 = LSB) controls it.
- R4: A 64-bit operation uses only predicate bit 0; bits 7..1 have no effect.
- R5: When `in_inv` is high, every predicate bit is complemented before it is used.
- R6: In non-zeroing mode (`in_zero` low), `out_be` bit b is 1 exactly when the byte b element is enabled, and `out_data` equals `in_data`.
- R7: In zeroing mode (`in_zero` high), `out_be` is 8'hFF. Each byte of `out_data` equals the input byte when its element is enabled and 0 when it is masked out.
- R8: When `in_pred_en` is low, the operation behaves as if the effective predicate were all ones. `in_pred` and `in_inv` are ignored.
- R9: 32-bit operations use only predicate bits 1..0, and 16-bit operations use only bits 3..0; the upper bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A register write is requested this cycle |
| in_data | input | 64 | ALU result |
| in_ew | input | 2 | Element width code |
| in_pred | input | 8 | Predicate bits, bit i for element i |
| in_inv | input | 1 | Complement the predicate |
| in_zero | input | 1 | Zeroing mode select |
| in_pred_en | input | 1 | Operation is predicated |
| out_valid | output | 1 | Write data and enables are valid |
| out_data | output | 64 | Data to write |
| out_be | output | 8 | Byte write enables |

## Verification
The bench sets the predicate bits above the ones a width actually uses. A design that indexed lanes wrongly would then enable bytes from those spare bits in 64-, 32- and 16-bit modes. Inverted predicates check whether the complement is applied at all, and whether it wrongly leaks into unpredicated operations. Zeroing cases with partly and fully masked words catch a design that clears the enables instead of the data, or that zeroes the wrong half. An idle cycle with an all-ones predicate catches enables that stay asserted without a valid request.

// File: rtl/wm_pkg.sv
package wm_pkg;

    typedef enum logic [1:0] {
        EW_D64 = 2'b00,
        EW_D32 = 2'b01,
        EW_D16 = 2'b10,
        EW_D8  = 2'b11
    } elem_w_e;

    // element index owning byte lane b for a width code, lanes = 2**log2_lanes
    function automatic int unsigned elem_of(int unsigned b, int unsigned code,
                                            int unsigned log2_lanes);
        int unsigned sh;
        sh = (code >= log2_lanes) ? 0 : (log2_lanes - code);
        return b >> sh;
    endfunction

endpackage

// File: rtl/wm_pred_prep.sv
module wm_pred_prep #(
    parameter int NUM_LANES = 8
) (
    input  logic [NUM_LANES-1:0] pred,
    input  logic                 inv,
    input  logic                 pred_en,
    output logic [NUM_LANES-1:0] eff
);
    always_comb begin
        if (!pred_en) eff = '1;
        else          eff = pred ^ {NUM_LANES{inv}};
    end
endmodule

// File: rtl/wm_lane_expand.sv
module wm_lane_expand
    import wm_pkg::*;
#(
    parameter int NUM_LANES  = 8,
    parameter int LOG2_LANES = $clog2(NUM_LANES)
) (
    input  logic [NUM_LANES-1:0] eff,
    input  elem_w_e              ew,
    output logic [NUM_LANES-1:0] byte_mask
);
    for (genvar b = 0; b < NUM_LANES; b++) begin : g_lane
        localparam int unsigned E64 = elem_of(b, 0, LOG2_LANES);
        localparam int unsigned E32 = elem_of(b, 1, LOG2_LANES);
        localparam int unsigned E16 = elem_of(b, 2, LOG2_LANES);
        localparam int unsigned E8  = elem_of(b, 3, LOG2_LANES);
        always_comb begin
            unique case (ew)
                EW_D64: byte_mask[b] = eff[E64];
                EW_D32: byte_mask[b] = eff[E32];
                EW_D16: byte_mask[b] = eff[E16];
                EW_D8:  byte_mask[b] = eff[E8];
                default: byte_mask[b] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/wm_data_gate.sv
module wm_data_gate #(
    parameter int NUM_LANES = 8,
    parameter int LANE_W    = 8,
    localparam int DATA_W   = NUM_LANES * LANE_W
) (
    input  logic [DATA_W-1:0]    data_in,
    input  logic [NUM_LANES-1:0] byte_mask,
    input  logic                 valid,
    input  logic                 zero_mode,
    output logic [DATA_W-1:0]    data_out,
    output logic [NUM_LANES-1:0] be_out
);
    for (genvar b = 0; b < NUM_LANES; b++) begin : g_byte
        always_comb begin
            if (zero_mode && !byte_mask[b])
                data_out[b*LANE_W +: LANE_W] = '0;
            else
                data_out[b*LANE_W +: LANE_W] = data_in[b*LANE_W +: LANE_W];
        end
    end

    always_comb begin
        if (!valid)         be_out = '0;
        else if (zero_mode) be_out = '1;
        else                be_out = byte_mask;
    end
endmodule

// File: rtl/lane_wmask_unit.sv
module lane_wmask_unit
    import wm_pkg::*;
#(
    parameter int NUM_LANES = 8,
    parameter int LANE_W    = 8,
    localparam int DATA_W   = NUM_LANES * LANE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [DATA_W-1:0]    in_data,
    input  logic [1:0]           in_ew,
    input  logic [NUM_LANES-1:0] in_pred,
    input  logic                 in_inv,
    input  logic                 in_zero,
    input  logic                 in_pred_en,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    out_data,
    output logic [NUM_LANES-1:0] out_be
);
    logic [NUM_LANES-1:0] eff_pred;
    logic [NUM_LANES-1:0] lane_mask;
    logic [DATA_W-1:0]    gated_data;
    logic [NUM_LANES-1:0] gated_be;
    elem_w_e              ew_sel;

    assign ew_sel = elem_w_e'(in_ew);

    wm_pred_prep #(.NUM_LANES(NUM_LANES)) u_prep (
        .pred    (in_pred),
        .inv     (in_inv),
        .pred_en (in_pred_en),
        .eff     (eff_pred)
    );

    wm_lane_expand #(.NUM_LANES(NUM_LANES)) u_expand (
        .eff       (eff_pred),
        .ew        (ew_sel),
        .byte_mask (lane_mask)
    );

    wm_data_gate #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_gate (
        .data_in   (in_data),
        .byte_mask (lane_mask),
        .valid     (in_valid),
        .zero_mode (in_zero),
        .data_out  (gated_data),
        .be_out    (gated_be)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_be    <= '0;
        end else begin
            out_valid <= in_valid;
            out_data  <= gated_data;
            out_be    <= gated_be;
        end
    end
endmodule

// File: rtl/wm_checker.sv
module wm_checker #(
    parameter int NUM_LANES = 8,
    parameter int LANE_W    = 8,
    localparam int DATA_W   = NUM_LANES * LANE_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [DATA_W-1:0]    in_data,
    input logic [1:0]           in_ew,
    input logic [NUM_LANES-1:0] in_pred,
    input logic                 in_inv,
    input logic                 in_zero,
    input logic                 in_pred_en,
    input logic                 out_valid,
    input logic [DATA_W-1:0]    out_data,
    input logic [NUM_LANES-1:0] out_be
);
    assert_valid_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    assert_idle_no_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> out_be == '0);

    assert_wide_all_or_none_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_zero && in_ew == 2'b00) |=> (out_be == '0 || out_be == '1));

    assert_keep_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_zero) |=> out_data == $past(in_data));

    assert_zero_full_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_zero) |=> out_be == '1);

    assert_zero_wide_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_zero && in_pred_en && in_ew == 2'b00 && (in_pred[0] == in_inv))
        |=> out_data == '0);

    assert_unpredicated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_pred_en) |=> (out_be == '1 && out_data == $past(in_data)));
endmodule

bind lane_wmask_unit wm_checker #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_wm_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ew      (in_ew),
    .in_pred    (in_pred),
    .in_inv     (in_inv),
    .in_zero    (in_zero),
    .in_pred_en (in_pred_en),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_be     (out_be)
);

// File: tb/lane_wmask_unit_tb.sv
module lane_wmask_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] in_data;
    logic [1:0]  in_ew;
    logic [7:0]  in_pred;
    logic        in_inv, in_zero, in_pred_en;
    logic        out_valid;
    logic [63:0] out_data;
    logic [7:0]  out_be;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    lane_wmask_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ew(in_ew), .in_pred(in_pred), .in_inv(in_inv), .in_zero(in_zero),
        .in_pred_en(in_pred_en), .out_valid(out_valid), .out_data(out_data),
        .out_be(out_be)
    );

    // {ew[2], pred[8], inv, zero, pred_en, expected element mask per byte[8]}
    localparam logic [20:0] VEC [12] = '{
        {2'b11, 8'hA5, 1'b0, 1'b0, 1'b1, 8'hA5},  // R3 R6 8-bit
        {2'b11, 8'hA5, 1'b1, 1'b0, 1'b1, 8'h5A},  // R5 invert
        {2'b10, 8'hF6, 1'b0, 1'b0, 1'b1, 8'h3C},  // R9 R3 16-bit, upper ignored
        {2'b01, 8'hFE, 1'b0, 1'b0, 1'b1, 8'hF0},  // R9 R3 32-bit
        {2'b00, 8'h01, 1'b0, 1'b0, 1'b1, 8'hFF},  // R4 64-bit on
        {2'b00, 8'hFE, 1'b0, 1'b0, 1'b1, 8'h00},  // R4 64-bit off
        {2'b00, 8'hFE, 1'b1, 1'b0, 1'b1, 8'hFF},  // R5 R4
        {2'b11, 8'h0F, 1'b0, 1'b1, 1'b1, 8'h0F},  // R7 8-bit zeroing
        {2'b01, 8'h01, 1'b0, 1'b1, 1'b1, 8'h0F},  // R7 32-bit zeroing
        {2'b10, 8'h09, 1'b1, 1'b1, 1'b1, 8'h3C},  // R7 R5 16-bit zeroing
        {2'b00, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00},  // R7 all masked
        {2'b11, 8'h00, 1'b1, 1'b0, 1'b0, 8'hFF}   // R8 unpredicated
    };

    localparam logic [63:0] D0 = 64'hF1E2_D3C4_B5A6_9788;

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [63:0] bits_of(input logic [7:0] m);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[b*8 +: 8] = {8{m[b]}};
        return r;
    endfunction

    task automatic drive(input logic v, input logic [63:0] d, input logic [1:0] ew,
                         input logic [7:0] p, input logic iv, input logic z, input logic pe);
        in_valid = v; in_data = d; in_ew = ew; in_pred = p;
        in_inv = iv; in_zero = z; in_pred_en = pe;
    endtask

    initial begin
        #150000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b0, '0, 2'b00, 8'h00, 1'b0, 1'b0, 1'b1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset valid", {63'd0, out_valid}, 64'd0);
        chk("R1 reset be", {56'd0, out_be}, 64'd0);
        chk("R1 reset data", out_data, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < 12; i++) begin
            logic [63:0] d;
            logic [7:0]  m;
            logic        z;
            d = D0 ^ {8{i[7:0]}};
            m = VEC[i][7:0];
            z = VEC[i][9];
            drive(1'b1, d, VEC[i][20:19], VEC[i][18:11], VEC[i][10], z, VEC[i][8]);
            @(negedge clk);
            chk($sformatf("R1 vec%0d valid", i), {63'd0, out_valid}, 64'd1);
            if (z) begin
                chk($sformatf("R7 vec%0d be", i), {56'd0, out_be}, 64'hFF);
                chk($sformatf("R7 vec%0d data", i), out_data, d & bits_of(m));
            end else begin
                chk($sformatf("R6 R3 vec%0d be", i), {56'd0, out_be}, {56'd0, m});
                chk($sformatf("R6 vec%0d data", i), out_data, d);
            end
        end

        // R2: idle cycle with all-ones predicate, zeroing on
        drive(1'b0, D0, 2'b11, 8'hFF, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        chk("R2 idle be", {56'd0, out_be}, 64'd0);
        chk("R1 idle valid", {63'd0, out_valid}, 64'd0);

        // R1: valid back after idle, then drop again
        drive(1'b1, D0, 2'b01, 8'h02, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        chk("R1 R3 resume be", {56'd0, out_be}, 64'hF0);
        drive(1'b0, D0, 2'b01, 8'h02, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        chk("R2 drop be", {56'd0, out_be}, 64'd0);

        // R8: unpredicated in zeroing mode keeps all data
        drive(1'b1, D0, 2'b10, 8'h00, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        chk("R8 zero unpred data", out_data, D0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule